// File: doc/BRIEF.md
# Power Gating Sequencer

This block governs one switchable logic domain. It drives the enable of the domain's power switch and the enable of the isolation cells at the domain's outputs. Power-down and power-up are each started by a one-cycle request pulse. Each one then runs a two-step sequence in a fixed order, with a programmable wait in front of each step. On the way down, isolation is applied first and the switch is opened second. On the way up, the switch is closed first and isolation is released second.

Software configures the block through a plain synchronous write/read port. One register holds an enable bit that decides whether a power-down request is obeyed. Two registers each hold a pair of 6-bit wait counts, one pair for the down sequence and one for the up sequence. A read-only register reports whether the most recent power-down request really switched the domain off. All waits are counted in cycles of the block's own clock. A busy output is high while a sequence is in progress.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset the switch is closed (`sw_en`=1), isolation is released (`iso_en`=0), `busy`=0, and every register reads 0.
- R2: Register map, with the address on `wr_addr`/`rd_addr` and read data valid on `rd_data` one cycle after the read address:
  - address 0 holds the gating-enable bit at bit 0;
  - address 1 holds the down-sequence waits, the isolation wait at bits 5:0 and the isolation-to-switch wait at bits 13:8;
  - address 2 holds the up-sequence waits, the switch wait at bits 5:0 and the switch-to-isolation wait at bits 13:8;
  - address 3 holds the status bit at bit 0 and ignores writes;
  - all other bits read 0.
- R3: A power-down request that arrives in the powered state while the gating-enable bit is 0 changes neither output and leaves `busy` at 0.
- R4: When a power-down request is accepted at a clock edge, `iso_en` rises N+1 edges later, where N is the isolation wait. With a wait of 0 it rises on the next edge.
- R5: `sw_en` falls M+1 edges after `iso_en` rises, where M is the isolation-to-switch wait. `sw_en` is never 0 while `iso_en` is 0.
- R6: A power-up request accepted in the off state makes `sw_en` rise S+1 edges later, where S is the switch wait.
- R7: `iso_en` falls I+1 edges after `sw_en` rises, where I is the switch-to-isolation wait.
- R8: The status bit becomes 1 when a power-down sequence opens the switch. It becomes 0 when a later power-down request is accepted, whether or not that request is obeyed.
- R9: Requests that arrive during a sequence are ignored. A power-up request is ignored unless the domain is off. A power-down request is ignored while the domain is off.
- R10: `busy` is 1 from the edge that accepts a request up to the edge that completes the sequence, and 0 otherwise.
- R11: The gating-enable bit is sampled only when a power-down request is accepted. Changing it during a sequence does not alter that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_req | input | 1 | Power-down request pulse |
| pup_req | input | 1 | Power-up request pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Registered read data |
| iso_en | output | 1 | Isolation enable, 1 = outputs clamped |
| sw_en | output | 1 | Power switch enable, 1 = domain supplied |
| busy | output | 1 | A sequence is in progress |

## Verification
The assertions assume that the wait registers do not change while a sequence is running. They also assume that request pulses come in the same cycle as no write to the gating-enable bit. The stimulus keeps to this by writing the waits only while `busy` is 0. The one exception is the gating-enable bit, which is deliberately rewritten in the middle of a sequence to show that it is ignored there. Stray requests are fired during both sequences and in both stable states to exercise the ignore rules. The waits cover both extremes, 0 and 63.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [2:0] {
    S_ON     = 3'd0,
    S_DN_ISO = 3'd1,
    S_DN_SW  = 3'd2,
    S_OFF    = 3'd3,
    S_UP_SW  = 3'd4,
    S_UP_ISO = 3'd5
  } pgs_state_t;

  // Wait counts for the four sequence steps.
  typedef struct packed {
    logic [5:0] dn_iso;
    logic [5:0] dn_sw;
    logic [5:0] up_sw;
    logic [5:0] up_iso;
  } pgs_waits_t;

  localparam int unsigned PGS_WAIT_W = 6;

endpackage

// File: rtl/pgs_regs.sv
module pgs_regs
  import pgs_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HI_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              status,
  output logic              gate_en,
  output pgs_waits_t        waits
);

  localparam int unsigned WW = PGS_WAIT_W;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DOWN = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_UP   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);

  logic [WW-1:0] dn_lo_q, dn_hi_q, up_lo_q, up_hi_q;
  logic          gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= 1'b0;
      dn_lo_q <= '0;
      dn_hi_q <= '0;
      up_lo_q <= '0;
      up_hi_q <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: gate_q <= wr_data[0];
        A_DOWN: begin
          dn_lo_q <= wr_data[WW-1:0];
          dn_hi_q <= wr_data[HI_LSB +: WW];
        end
        A_UP: begin
          up_lo_q <= wr_data[WW-1:0];
          up_hi_q <= wr_data[HI_LSB +: WW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      unique case (rd_addr)
        A_CTRL: rd_data[0] <= gate_q;
        A_DOWN: begin
          rd_data[WW-1:0]      <= dn_lo_q;
          rd_data[HI_LSB +: WW] <= dn_hi_q;
        end
        A_UP: begin
          rd_data[WW-1:0]      <= up_lo_q;
          rd_data[HI_LSB +: WW] <= up_hi_q;
        end
        A_STAT: rd_data[0] <= status;
        default: ;
      endcase
    end
  end

  assign gate_en       = gate_q;
  assign waits.dn_iso  = dn_lo_q;
  assign waits.dn_sw   = dn_hi_q;
  assign waits.up_sw   = up_lo_q;
  assign waits.up_iso  = up_hi_q;

  // Status address is read-only: a write there leaves the fields unchanged.
  AST_STAT_RO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_STAT) |=> ($stable(gate_q) && $stable(dn_lo_q) && $stable(up_hi_q))); // R2

endmodule

// File: rtl/pgs_delay.sv
module pgs_delay #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val))); // R4

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!load && zero) |=> zero); // R10

endmodule

// File: rtl/pgs_fsm.sv
module pgs_fsm
  import pgs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pdn_req,
  input  logic                  pup_req,
  input  logic                  gate_en,
  input  pgs_waits_t            waits,
  input  logic                  cnt_zero,
  output logic                  cnt_load,
  output logic [PGS_WAIT_W-1:0] cnt_val,
  output logic                  iso_en,
  output logic                  sw_en,
  output logic                  busy,
  output logic                  status
);

  pgs_state_t st_q, st_d;
  logic iso_q, iso_d, sw_q, sw_d, stat_q, stat_d, busy_q;

  always_comb begin
    st_d     = st_q;
    iso_d    = iso_q;
    sw_d     = sw_q;
    stat_d   = stat_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (st_q)
      S_ON: if (pdn_req) begin
        stat_d = 1'b0;
        if (gate_en) begin
          st_d     = S_DN_ISO;
          cnt_load = 1'b1;
          cnt_val  = waits.dn_iso;
        end
      end
      S_DN_ISO: if (cnt_zero) begin
        iso_d    = 1'b1;
        st_d     = S_DN_SW;
        cnt_load = 1'b1;
        cnt_val  = waits.dn_sw;
      end
      S_DN_SW: if (cnt_zero) begin
        sw_d   = 1'b0;
        stat_d = 1'b1;
        st_d   = S_OFF;
      end
      S_OFF: if (pup_req) begin
        st_d     = S_UP_SW;
        cnt_load = 1'b1;
        cnt_val  = waits.up_sw;
      end
      S_UP_SW: if (cnt_zero) begin
        sw_d     = 1'b1;
        st_d     = S_UP_ISO;
        cnt_load = 1'b1;
        cnt_val  = waits.up_iso;
      end
      S_UP_ISO: if (cnt_zero) begin
        iso_d = 1'b0;
        st_d  = S_ON;
      end
      default: st_d = S_ON;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_ON;
      iso_q  <= 1'b0;
      sw_q   <= 1'b1;
      stat_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      iso_q  <= iso_d;
      sw_q   <= sw_d;
      stat_q <= stat_d;
      busy_q <= (st_d != S_ON) && (st_d != S_OFF);
    end
  end

  assign iso_en = iso_q;
  assign sw_en  = sw_q;
  assign busy   = busy_q;
  assign status = stat_q;

  AST_DECLINE: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_ON && pdn_req && !gate_en) |=> (st_q == S_ON && !busy_q)); // R3

  AST_PUP_IN_ON: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_ON && !pdn_req) |=> (st_q == S_ON)); // R9

  AST_PDN_IN_OFF: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_OFF && !pup_req) |=> (st_q == S_OFF && !sw_q)); // R9

  AST_STAT_ON_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q) |-> !sw_q); // R8

  AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_ON || st_q == S_OFF) |-> !busy_q); // R10

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pgs_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HI_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdn_req,
  input  logic              pup_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              iso_en,
  output logic              sw_en,
  output logic              busy
);

  pgs_waits_t            waits;
  logic                  gate_en, status, cnt_load, cnt_zero;
  logic [PGS_WAIT_W-1:0] cnt_val;

  pgs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_LSB(HI_LSB)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .status(status),
    .gate_en(gate_en), .waits(waits)
  );

  pgs_delay #(.W(PGS_WAIT_W)) u_dly (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  pgs_fsm u_fsm (
    .clk(clk), .rst(rst), .pdn_req(pdn_req), .pup_req(pup_req),
    .gate_en(gate_en), .waits(waits), .cnt_zero(cnt_zero),
    .cnt_load(cnt_load), .cnt_val(cnt_val),
    .iso_en(iso_en), .sw_en(sw_en), .busy(busy), .status(status)
  );

  AST_ISO_GUARDS_OFF: assert property (@(posedge clk) disable iff (rst)
    !sw_en |-> iso_en); // R5

  AST_SW_OPEN_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(sw_en) |-> $past(iso_en)); // R5

  AST_SW_CLOSE_ORDER: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_en) |-> $past(sw_en)); // R7

  AST_ISO_RISE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(iso_en) |-> $past(busy)); // R4

  AST_SW_RISE_ISO: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en) |-> (iso_en && busy)); // R6

endmodule

// File: tb/sim_pwr_gate_seq.sv
`timescale 1ns/1ps
module sim_pwr_gate_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pdn_req = 1'b0, pup_req = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        iso_en, sw_en, busy;

  always #2.5 clk = ~clk;

  pwr_gate_seq u0 (
    .clk(clk), .rst(rst), .pdn_req(pdn_req), .pup_req(pup_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .iso_en(iso_en), .sw_en(sw_en), .busy(busy)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model: deadlines in absolute edge numbers.
  int cyc = 0;
  int m_mode = 0;  // 0 on, 1 going down, 2 off, 3 going up
  int t_a = 0, t_b = 0;
  bit m_iso = 0, m_sw = 1, m_stat = 0;
  int m_gate = 0, m_dn_iso = 0, m_dn_sw = 0, m_up_sw = 0, m_up_iso = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      m_mode = 0; m_iso = 0; m_sw = 1; m_stat = 0;
    end else begin
      case (m_mode)
        0: if (pdn_req) begin
          m_stat = 0;
          if (m_gate != 0) begin
            m_mode = 1;
            t_a = cyc + 1 + m_dn_iso;
            t_b = t_a + 1 + m_dn_sw;
          end
        end
        1: begin
          if (cyc == t_a) m_iso = 1;
          if (cyc == t_b) begin m_sw = 0; m_stat = 1; m_mode = 2; end
        end
        2: if (pup_req) begin
          m_mode = 3;
          t_a = cyc + 1 + m_up_sw;
          t_b = t_a + 1 + m_up_iso;
        end
        default: begin
          if (cyc == t_a) m_sw = 1;
          if (cyc == t_b) begin m_iso = 0; m_mode = 0; end
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison of every output against the model.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 R7 iso_en", {31'b0, iso_en}, {31'b0, m_iso});
      chk("R5 R6 sw_en", {31'b0, sw_en}, {31'b0, m_sw});
      chk("R10 busy", {31'b0, busy}, {31'b0, bit'(m_mode == 1 || m_mode == 3)});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: m_gate = int'(d[0]);
      2'd1: begin m_dn_iso = int'(d[5:0]); m_dn_sw = int'(d[13:8]); end
      2'd2: begin m_up_sw = int'(d[5:0]); m_up_iso = int'(d[13:8]); end
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse_dn();
    @(negedge clk); pdn_req = 1'b1;
    @(negedge clk); pdn_req = 1'b0;
  endtask

  task automatic pulse_up();
    @(negedge clk); pup_req = 1'b1;
    @(negedge clk); pup_req = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 400 && (m_mode == 1 || m_mode == 3); i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 sw_en", {31'b0, sw_en}, 32'd1);
    chk("R1 iso_en", {31'b0, iso_en}, 32'd0);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    for (int a = 0; a < 4; a++) rd_chk("R1 reg", 2'(a), 32'd0);

    // R2 field placement, reserved bits and read-only status
    wr(2'd0, 32'hFFFF_FFFF); rd_chk("R2 ctrl", 2'd0, 32'h1);
    wr(2'd1, 32'hFFFF_FFFF); rd_chk("R2 down", 2'd1, 32'h3F3F);
    wr(2'd2, 32'h0000_2A15); rd_chk("R2 up", 2'd2, 32'h2A15);
    wr(2'd3, 32'hFFFF_FFFF); rd_chk("R2 stat ro", 2'd3, 32'h0);
    rd_chk("R2 ctrl kept", 2'd0, 32'h1);

    // R3 declined request
    wr(2'd0, 32'h0);
    pulse_dn();
    repeat (5) @(negedge clk);
    chk("R3 sw_en", {31'b0, sw_en}, 32'd1);
    chk("R3 busy", {31'b0, busy}, 32'd0);
    rd_chk("R3 stat", 2'd3, 32'h0);

    // R4 R5 R8 normal down
    wr(2'd0, 32'h1);
    wr(2'd1, {18'b0, 6'd5, 2'b0, 6'd3});
    wr(2'd2, {18'b0, 6'd4, 2'b0, 6'd2});
    pulse_dn();
    repeat (2) @(negedge clk);
    pulse_up();  // R9 ignored mid-sequence
    pulse_dn();  // R9 ignored mid-sequence
    settle();
    chk("R5 off", {31'b0, sw_en}, 32'd0);
    rd_chk("R8 stat set", 2'd3, 32'h1);
    pulse_dn();  // R9 ignored while off
    repeat (4) @(negedge clk);
    chk("R9 still off", {31'b0, sw_en}, 32'd0);

    // R6 R7 up with stray requests
    pulse_up();
    pulse_dn();
    pulse_up();
    settle();
    chk("R7 iso released", {31'b0, iso_en}, 32'd0);
    pulse_up();  // R9 ignored while on
    repeat (3) @(negedge clk);
    chk("R9 on idle", {31'b0, busy}, 32'd0);

    // zero waits
    wr(2'd1, 32'h0); wr(2'd2, 32'h0);
    pulse_dn(); settle();
    chk("R4 zero down", {31'b0, sw_en}, 32'd0);
    pulse_up(); settle();
    chk("R6 zero up", {31'b0, sw_en}, 32'd1);

    // maximum waits and R11 gate change mid-sequence
    wr(2'd1, 32'h3F3F); wr(2'd2, 32'h3F3F);
    pulse_dn();
    repeat (10) @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h0;
    @(negedge clk); wr_en = 1'b0;
    settle();
    chk("R11 still went off", {31'b0, sw_en}, 32'd0);
    m_gate = 0;
    pulse_up(); settle();
    rd_chk("R8 stat before decline", 2'd3, 32'h1);
    pulse_dn();
    repeat (3) @(negedge clk);
    rd_chk("R8 stat cleared", 2'd3, 32'h0);
    chk("R3 powered", {31'b0, sw_en}, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule